// File: doc/BRIEF.md
# Header Bitstream Writer with Start-Code Protection

This block turns a sequence of header syntax commands into a byte stream packed into 32-bit words. Each command does one of these: appends a fixed-width field, appends an unsigned or signed Exp-Golomb code, pads to a byte boundary, drains all partial data, or switches start-code protection on or off. Bits collect in a single left-aligned 32-bit shifter. Whole bytes leave the shifter from the top. Each byte then passes through an optional stage that inserts a 0x03 byte wherever the output would otherwise hold a start-code-like pattern. The bytes are then packed, most significant lane first, into output words.

Commands arrive on a valid/ready channel and words leave on a valid/ready channel. A running counter reports how many bits the block has emitted. The command channel stays not-ready while earlier work is still in progress. This covers pending bits, a byte waiting behind an inserted 0x03, a drain, and a finished word that has not been taken.

Top module: `hdr_bitwriter`

## Requirements
- R1: Command code 0 appends the low `cmd_nbits` bits (1 to 32) of `cmd_value`, most significant first. Bits above that width are ignored, and a width of 0 appends nothing.
- R2: Emitted bytes fill a word in lanes 31:24, 23:16, 15:8 and then 7:0. The word is offered after its fourth byte, and while it is offered and not taken `word_data` holds steady.
- R3: Command code 1 appends the unsigned Exp-Golomb code of `cmd_value`: L zero bits, then v+1 in L+1 bits, where L = floor(log2(v+1)).
- R4: Command code 2 treats `cmd_value` as signed x. It appends the unsigned code of 2x-1 when x>0, of -2x when x<0, and of 0 when x=0.
- R5: Command code 3 appends zero bits up to the next byte boundary. When the bit position is already on a boundary it appends nothing.
- R6: While protection is on, a byte of 0x00, 0x01 or 0x03 that follows two or more emitted zero bytes is preceded by an inserted 0x03, and the zero run then restarts. While protection is off, no byte is inserted.
- R7: Command code 5 sets protection to `cmd_value[0]`. A change of setting clears the zero-run count, and writing the current setting again has no effect on it.
- R8: Command code 4 drains the block. A partial byte is emitted left-aligned with zero fill and is checked for protection first. Only its real bit count is added to the counter, and the zero run is cleared. A partly filled word is then offered with its unused low lanes at zero.
- R9: `bit_count` grows by 8 for each data byte and for each inserted 0x03, and by the real bit count of a drained partial byte.
- R10: `cmd_ready` is low while bits are pending, while a whole byte (including one behind an inserted 0x03) waits, during a drain, and while a word is offered.
- R11: After reset no word is offered, `bit_count` is 0, `cmd_ready` is high and protection is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high with `cmd_valid` |
| cmd_op | input | 3 | Command code (0 fixed, 1 unsigned EG, 2 signed EG, 3 align, 4 drain, 5 protection; 6 and 7 do nothing) |
| cmd_value | input | 32 | Field value, Exp-Golomb operand, or protection setting in bit 0 |
| cmd_nbits | input | 6 | Field width for code 0 |
| word_valid | output | 1 | Output word offered |
| word_ready | input | 1 | Output word taken |
| word_data | output | 32 | Output word, first byte in bits 31:24 |
| bit_count | output | CNT_W | Bits emitted so far |

## Verification
The hardest situation to reach is a 0x03 insertion that lands on a partial byte during a drain while the output side is stalled. That case needs a zero run of two built across earlier commands, a sub-byte remainder of zeros, and `word_ready` held low at the moment the word fills. The stimulus builds zero runs with wide zero fields and then ends on a short zero field followed by a drain. It runs the same patterns under random output backpressure. It also toggles protection between zero bytes, so the run reset and the same-value no-op each show up in the words that come out.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
  localparam int ACC_W      = 32;
  localparam int BYTE_W     = 8;
  localparam int LEN_W      = 6;
  localparam int CODE_W     = ACC_W + 1;
  localparam int WORD_BYTES = ACC_W / BYTE_W;
  localparam int IDX_W      = $clog2(WORD_BYTES);

  typedef enum logic [2:0] {
    OP_FIXED = 3'd0,
    OP_UEG   = 3'd1,
    OP_SEG   = 3'd2,
    OP_ALIGN = 3'd3,
    OP_DRAIN = 3'd4,
    OP_PROT  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    FL_IDLE  = 2'd0,
    FL_DRAIN = 2'd1,
    FL_REL   = 2'd2
  } fl_e;
endpackage

// File: rtl/hbw_golomb.sv
module hbw_golomb
  import hbw_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [ACC_W-1:0]  value,
  input  logic [LEN_W-1:0]  nbits,
  output logic [CODE_W-1:0] code,
  output logic [LEN_W-1:0]  code_len,
  output logic [LEN_W-1:0]  lead
);
  logic [CODE_W-1:0] mapped;
  logic [CODE_W-1:0] plus1;
  logic [LEN_W-1:0]  msb;
  logic [LEN_W-1:0]  n;

  always_comb begin
    // signed-to-unsigned mapping, else identity
    if (op == OP_SEG) begin
      if (value == '0)         mapped = '0;
      else if (!value[ACC_W-1]) mapped = {value, 1'b0} - CODE_W'(1);
      else                      mapped = {(~value) + ACC_W'(1), 1'b0};
    end else begin
      mapped = {1'b0, value};
    end
    plus1 = mapped + CODE_W'(1);
    msb = '0;
    for (int i = 0; i < CODE_W; i++) begin
      if (plus1[i]) msb = LEN_W'(i);
    end
    n = (nbits > LEN_W'(ACC_W)) ? LEN_W'(ACC_W) : nbits;
    code = '0;
    code_len = '0;
    lead = '0;
    if (op == OP_FIXED) begin
      code = ((CODE_W'(1) << n) - CODE_W'(1)) & {1'b0, value};
      code_len = n;
    end else if (op == OP_UEG || op == OP_SEG) begin
      code = plus1;
      code_len = msb + LEN_W'(1);
      lead = msb;
    end
  end
endmodule

// File: rtl/hbw_prot.sv
module hbw_prot
  import hbw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              slot_ok,
  input  logic              clr_run,
  input  logic              set_en,
  input  logic              set_val,
  output logic              out_we,
  output logic [BYTE_W-1:0] out_byte,
  output logic              take,
  output logic              inserted
);
  logic       prot_q, prot_d;
  logic [1:0] run_q, run_d;
  logic       hit;

  always_comb begin
    hit = prot_q && (run_q == 2'd2) &&
          (in_byte == 8'h00 || in_byte == 8'h01 || in_byte == 8'h03);
    out_we   = in_valid && slot_ok;
    inserted = out_we && hit;
    take     = out_we && !hit;
    out_byte = hit ? 8'h03 : in_byte;
    prot_d = prot_q;
    run_d  = run_q;
    if (set_en && (set_val != prot_q)) begin
      prot_d = set_val;
      run_d  = 2'd0;
    end else if (inserted) begin
      run_d = 2'd0;
    end else if (take) begin
      if (clr_run)               run_d = 2'd0;
      else if (prot_q && in_byte == 8'h00)
        run_d = (run_q == 2'd2) ? 2'd2 : run_q + 2'd1;
      else if (prot_q)           run_d = 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      run_q  <= 2'd0;
    end else begin
      prot_q <= prot_d;
      run_q  <= run_d;
    end
  end

  // R6
  ins_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inserted |=> !inserted);
  // R7
  prot_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_val != prot_q) |=> (run_q == 2'd0));
endmodule

// File: rtl/hbw_packer.sv
module hbw_packer
  import hbw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_we,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              release_req,
  input  logic              word_ready,
  output logic              word_valid,
  output logic [ACC_W-1:0]  word_data,
  output logic              space
);
  logic [ACC_W-1:0] word_q, word_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             val_q, val_d;

  always_comb begin
    word_d = word_q;
    idx_d  = idx_q;
    val_d  = val_q;
    if (val_q && word_ready) begin
      val_d  = 1'b0;
      word_d = '0;
    end
    if (byte_we) begin
      word_d[(WORD_BYTES - 1 - int'(idx_q)) * BYTE_W +: BYTE_W] = byte_in;
      if (idx_q == IDX_W'(WORD_BYTES - 1)) begin
        val_d = 1'b1;
        idx_d = '0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end else if (release_req && !val_q && idx_q != '0) begin
      val_d = 1'b1;
      idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
      val_q  <= 1'b0;
    end else begin
      if (word_d != word_q) word_q <= word_d;
      idx_q <= idx_d;
      val_q <= val_d;
    end
  end

  assign word_valid = val_q;
  assign word_data  = word_q;
  assign space      = !val_q;

  // R2
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q && !word_ready) |=> (val_q && $stable(word_q)));
  // R2
  lane_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(val_q) |=> (idx_q == '0));
endmodule

// File: rtl/hdr_bitwriter.sv
module hdr_bitwriter
  import hbw_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [31:0]      cmd_value,
  input  logic [5:0]       cmd_nbits,
  output logic             word_valid,
  input  logic             word_ready,
  output logic [31:0]      word_data,
  output logic [CNT_W-1:0] bit_count
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [LEN_W-1:0]  fill_q, fill_d, pend_n_q, pend_n_d, zero_q, zero_d;
  logic [CODE_W-1:0] pend_v_q, pend_v_d;
  fl_e               flush_q, flush_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  logic [CODE_W-1:0] g_code;
  logic [LEN_W-1:0]  g_len, g_lead;
  logic              pend_idle, full_byte, part_byte, cmd_fire;
  logic              ep_we, ep_take, ep_ins, pk_space;
  logic [BYTE_W-1:0] ep_byte;
  logic [LEN_W-1:0]  room, k, shr;
  logic [CODE_W-1:0] chunk;
  logic [63:0]       placed;

  hbw_golomb u_gol (
    .op(cmd_op), .value(cmd_value), .nbits(cmd_nbits),
    .code(g_code), .code_len(g_len), .lead(g_lead)
  );

  assign pend_idle = (pend_n_q == '0) && (zero_q == '0);
  assign full_byte = (fill_q >= LEN_W'(BYTE_W));
  assign part_byte = (flush_q == FL_DRAIN) && pend_idle &&
                     (fill_q != '0) && !full_byte;
  assign cmd_ready = pend_idle && !full_byte && (flush_q == FL_IDLE) && pk_space;
  assign cmd_fire  = cmd_valid && cmd_ready;

  hbw_prot u_prot (
    .clk(clk), .rst_n(rst_i_n),
    .in_valid(full_byte || part_byte), .in_byte(acc_q[ACC_W-1 -: BYTE_W]),
    .slot_ok(pk_space), .clr_run(part_byte),
    .set_en(cmd_fire && cmd_op == OP_PROT), .set_val(cmd_value[0]),
    .out_we(ep_we), .out_byte(ep_byte), .take(ep_take), .inserted(ep_ins)
  );

  hbw_packer u_pack (
    .clk(clk), .rst_n(rst_i_n),
    .byte_we(ep_we), .byte_in(ep_byte),
    .release_req(flush_q == FL_REL), .word_ready(word_ready),
    .word_valid(word_valid), .word_data(word_data), .space(pk_space)
  );

  // chunk of pending bits that fits in the free part of the shifter
  always_comb begin
    room = LEN_W'(ACC_W) - fill_q;
    if (zero_q != '0) k = (zero_q < room) ? zero_q : room;
    else              k = (pend_n_q < room) ? pend_n_q : room;
    shr    = pend_n_q - k;
    chunk  = (pend_v_q >> shr) & ((CODE_W'(1) << k) - CODE_W'(1));
    placed = 64'(chunk) << (room - k);
  end

  always_comb begin
    acc_d    = acc_q;
    fill_d   = fill_q;
    pend_n_d = pend_n_q;
    pend_v_d = pend_v_q;
    zero_d   = zero_q;
    flush_d  = flush_q;
    cnt_d    = cnt_q;
    if (ep_take) begin
      if (part_byte) begin
        acc_d  = '0;
        fill_d = '0;
        cnt_d  = cnt_q + CNT_W'(fill_q);
      end else begin
        acc_d  = acc_q << BYTE_W;
        fill_d = fill_q - LEN_W'(BYTE_W);
        cnt_d  = cnt_q + CNT_W'(BYTE_W);
      end
    end
    if (ep_ins) cnt_d = cnt_q + CNT_W'(BYTE_W);
    if (!pend_idle && !full_byte) begin
      fill_d = fill_q + k;
      if (zero_q != '0) begin
        zero_d = zero_q - k;
      end else begin
        acc_d    = acc_q | placed[ACC_W-1:0];
        pend_n_d = pend_n_q - k;
      end
    end
    case (flush_q)
      FL_DRAIN: if (pend_idle && fill_q == '0) flush_d = FL_REL;
      FL_REL:   if (pk_space) flush_d = FL_IDLE;
      default:  flush_d = FL_IDLE;
    endcase
    if (cmd_fire) begin
      case (cmd_op)
        OP_FIXED, OP_UEG, OP_SEG: begin
          pend_v_d = g_code;
          pend_n_d = g_len;
          zero_d   = g_lead;
        end
        OP_ALIGN: zero_d = LEN_W'((4'd8 - {1'b0, fill_q[2:0]}) & 4'd7);
        OP_DRAIN: flush_d = FL_DRAIN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      acc_q    <= '0;
      fill_q   <= '0;
      pend_n_q <= '0;
      pend_v_q <= '0;
      zero_q   <= '0;
      flush_q  <= FL_IDLE;
      cnt_q    <= '0;
    end else begin
      acc_q    <= acc_d;
      fill_q   <= fill_d;
      pend_n_q <= pend_n_d;
      if (cmd_fire) pend_v_q <= pend_v_d;
      zero_q   <= zero_d;
      flush_q  <= flush_d;
      cnt_q    <= cnt_d;
    end
  end

  assign bit_count = cnt_q;

  // R1
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    fill_q <= LEN_W'(ACC_W));
  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cnt_q - $past(cnt_q)) <= CNT_W'(BYTE_W));
  // R8
  drain_busy_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_fire && cmd_op == OP_DRAIN) |=> !cmd_ready);
  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (word_valid && !word_ready) |=> !cmd_ready);
endmodule

// File: tb/sim_hdr_bitwriter.sv
module sim_hdr_bitwriter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [31:0] cmd_value = 32'd0;
  logic [5:0]  cmd_nbits = 6'd0;
  logic        word_valid;
  logic        word_ready = 1'b0;
  logic [31:0] word_data;
  logic [31:0] bit_count;

  always #2.5 clk = ~clk;

  hdr_bitwriter u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_value(cmd_value), .cmd_nbits(cmd_nbits),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
    .bit_count(bit_count)
  );

  int nchk = 0;
  int nfail = 0;
  string cur_req = "R11";
  int rdy_mode = 0;
  logic [31:0] expq[$];

  // reference model state
  bit          mq[$];
  logic [31:0] mword = 0;
  int          midx = 0;
  bit          mprot = 0;
  int          mrun = 0;
  longint      mcnt = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_put(input logic [7:0] b);
    mword[31 - 8*midx -: 8] = b;
    midx++;
    if (midx == 4) begin
      expq.push_back(mword);
      mword = 0;
      midx = 0;
    end
  endtask

  task automatic m_byte(input logic [7:0] b);
    if (mprot && mrun >= 2 && (b == 8'h00 || b == 8'h01 || b == 8'h03)) begin
      m_put(8'h03);
      mcnt += 8;
      mrun = 0;
    end
    if (mprot) mrun = (b == 8'h00) ? mrun + 1 : 0;
    m_put(b);
    mcnt += 8;
  endtask

  task automatic m_bits(input longint v, input int n);
    logic [7:0] b;
    for (int i = n - 1; i >= 0; i--) mq.push_back(v[i]);
    while (mq.size() >= 8) begin
      b = 0;
      for (int j = 0; j < 8; j++) b = {b[6:0], mq.pop_front()};
      m_byte(b);
    end
  endtask

  task automatic m_ue(input longint v);
    longint u = v + 1;
    int l = 0;
    while ((u >> (l + 1)) != 0) l++;
    m_bits(0, l);
    m_bits(u, l + 1);
  endtask

  task automatic send(input logic [2:0] op, input logic [31:0] v, input logic [5:0] n);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_value = v; cmd_nbits = n;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_fixed(input logic [31:0] v, input int n);
    longint mv = longint'(v) & ((64'd1 << n) - 1);
    m_bits(mv, n);
    send(3'd0, v, 6'(n));
  endtask

  task automatic do_ue(input logic [31:0] v);
    m_ue(longint'(v));
    send(3'd1, v, 6'd0);
  endtask

  task automatic do_se(input int x);
    longint lx = x;
    longint u = (lx > 0) ? 2*lx - 1 : ((lx < 0) ? -2*lx : 0);
    m_ue(u);
    send(3'd2, x, 6'd0);
  endtask

  task automatic do_align();
    int pad = (8 - (mq.size() % 8)) % 8;
    m_bits(0, pad);
    send(3'd3, 32'd0, 6'd0);
  endtask

  task automatic do_prot(input bit v);
    if (v != mprot) begin mprot = v; mrun = 0; end
    send(3'd5, {31'd0, v}, 6'd0);
  endtask

  task automatic do_drain();
    logic [7:0] b;
    int n = mq.size();
    if (n > 0) begin
      b = 0;
      for (int j = 0; j < 8; j++) b = {b[6:0], (j < n) ? mq[j] : 1'b0};
      if (mprot && mrun >= 2 && (b == 8'h00 || b == 8'h01 || b == 8'h03)) begin
        m_put(8'h03);
        mcnt += 8;
      end
      m_put(b);
      mcnt += n;
      mrun = 0;
      mq.delete();
    end
    if (midx > 0) begin
      expq.push_back(mword);
      mword = 0;
      midx = 0;
    end
    send(3'd4, 32'd0, 6'd0);
  endtask

  task automatic chk_cnt(input string req);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    check(req, 64'(bit_count), 64'(mcnt));
  endtask

  // scoreboard monitor and output-side driver
  always @(negedge clk) begin
    if (rdy_mode == 0)      word_ready = 1'b1;
    else if (rdy_mode == 1) word_ready = ($urandom % 3) != 0;
    else                    word_ready = 1'b0;
    if (rst_n && word_valid && word_ready) begin
      if (expq.size() == 0) check({cur_req, " extra word"}, 64'(word_data), 64'hDEAD);
      else check(cur_req, 64'(word_data), 64'(expq.pop_front()));
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    report();
  end

  logic [31:0] held;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11", 64'(word_valid), 0);
    check("R11", 64'(bit_count), 0);
    check("R11", 64'(cmd_ready), 1);

    // R1: masking and MSB-first order, R2 lanes
    cur_req = "R1";
    do_fixed(32'hA5, 8);
    do_fixed(32'hFFFF_FFFF, 4);
    do_fixed(32'h0, 4);
    do_fixed(32'h1234_5678, 32);
    do_fixed(32'h7, 0);
    do_fixed(32'h3, 2);
    chk_cnt("R9");
    cur_req = "R2";
    do_drain();
    chk_cnt("R8");

    // R3 unsigned codes
    cur_req = "R3";
    do_ue(0); do_ue(1); do_ue(2); do_ue(3); do_ue(7); do_ue(254);
    do_ue(32'hFFFF_FFFF); do_ue(32'h8000_0000);
    chk_cnt("R3");
    do_drain();

    // R4 signed codes
    cur_req = "R4";
    do_se(0); do_se(1); do_se(-1); do_se(5); do_se(-5);
    do_se(32'sh7FFF_FFFF); do_se(32'sh8000_0000);
    chk_cnt("R4");
    do_drain();

    // R5 alignment, twice in a row the second is a no-op
    cur_req = "R5";
    do_fixed(32'h5, 3);
    do_align();
    chk_cnt("R5");
    do_align();
    chk_cnt("R5");
    do_fixed(32'hC3, 8);
    do_drain();

    // R6 insertion with protection on, none with it off
    cur_req = "R6";
    do_prot(1);
    do_fixed(32'h0000_0000, 24);
    do_fixed(32'h0000_01, 24);
    do_fixed(32'h0000_03, 24);
    do_fixed(32'h0000_02, 24);
    do_fixed(32'h0, 32);
    chk_cnt("R9");
    do_drain();
    do_prot(0);
    do_fixed(32'h0000_0000, 24);
    do_fixed(32'h0000_01, 24);
    chk_cnt("R6");
    do_drain();

    // R7 same-value write keeps the run, a change clears it
    cur_req = "R7";
    do_prot(1);
    do_fixed(32'h0, 16);
    do_prot(1);
    do_fixed(32'h01, 8);
    do_fixed(32'h0, 16);
    do_prot(0);
    do_prot(1);
    do_fixed(32'h01, 8);
    chk_cnt("R7");
    do_drain();

    // R8 partial byte during drain needs an insertion first
    cur_req = "R8";
    do_fixed(32'h0, 16);
    do_fixed(32'h0, 3);
    do_drain();
    chk_cnt("R8");
    do_prot(0);

    // R10 backpressure: word held, no commands accepted
    cur_req = "R10";
    rdy_mode = 2;
    do_fixed(32'hCAFE_F00D, 32);
    repeat (10) @(negedge clk);
    check("R10", 64'(word_valid), 1);
    check("R10", 64'(cmd_ready), 0);
    held = word_data;
    repeat (5) @(negedge clk);
    check("R2", 64'(word_data), 64'(held));
    rdy_mode = 0;
    chk_cnt("R10");

    // mixed traffic under random backpressure
    cur_req = "R9";
    rdy_mode = 1;
    for (int i = 0; i < 300; i++) begin
      int sel = $urandom % 10;
      if (sel < 4)       do_fixed(($urandom % 4 == 0) ? 32'd0 : $urandom, 1 + $urandom % 32);
      else if (sel < 6)  do_ue($urandom % 1000);
      else if (sel < 8)  do_se(int'($urandom % 2001) - 1000);
      else if (sel == 8) do_align();
      else               do_prot(($urandom % 2) == 1);
      if (i % 50 == 49) begin do_drain(); chk_cnt("R9"); end
    end
    do_drain();
    chk_cnt("R9");

    rdy_mode = 0;
    for (int i = 0; i < 200 && (expq.size() != 0 || word_valid); i++) @(negedge clk);
    check("R2", 64'(expq.size()), 0);
    report();
  end
endmodule